// File: doc/BRIEF.md
# Dual-Channel Capture/Compare Timer Channel

This block is a single timer channel built around two registers, A and B, that watch a shared free-running time base bus. A 4-bit mode field decides what the pair does. In the input modes the registers latch the time base when the synchronized input pin changes level. Depending on the mode, this yields one timestamp, a pulse width (A and B hold the two edges) or a period (A and B hold two successive edges). In the output modes the registers are compare values. A match on A sets an output flip-flop and a match on B clears it. PWM mode adds a selectable resolution, which it gets by ignoring the upper time base bits.

One polarity bit has two meanings. In the input modes it chooses whether a rising or a falling edge is the active one. In the output modes it inverts the pin. In PWM, new compare values wait in shadow registers and are loaded only when the masked time base passes through zero, so a period is never cut short. A one-cycle event flag marks each capture or flagged match. The time base counter, interrupt routing and bus bridge sit outside the block.

Top module: `dual_ccr_timer`

## Requirements
- R1: Synchronous active-high reset clears the control register (mode 0000, polarity 0), both registers and both shadow copies, the output flip-flop and the flag. `pin_out`, `flag_out`, `reg_a` and `reg_b` therefore all read zero after reset.
- R2: A write with `wr_sel`=0 loads the control register: mode from `wr_data[3:0]` and polarity from `wr_data[4]`. `wr_sel`=1 writes A and `wr_sel`=2 writes B. Outside PWM a register write shows on `reg_a`/`reg_b` one cycle later.
- R3: Mode 0000 and the reserved codes 0110 and 0111 behave as disabled. Pin activity captures nothing, time base matches have no effect, the flag stays low and `pin_out` stays low.
- R4: The input pin passes through two synchronizer flops and one edge register. A level change presented before clock edge k is captured at edge k+2, using the time base value present at that edge. No capture happens earlier.
- R5: Input capture (0011). On the active edge (polarity 0: rising, polarity 1: falling), A loads the time base and the flag pulses. The other edge does nothing, and B is never touched.
- R6: Pulse width (0001). The active edge loads A without a flag. The opposite edge loads B and pulses the flag.
- R7: Period (0010). Each active edge moves A into B, loads A with the time base and pulses the flag. The opposite edge does nothing.
- R8: Output compare (0100, 0101). A time base equal to A sets the flip-flop, and equal to B clears it. When both match, clear wins. Mode 0100 flags only on a B match. Mode 0101 flags on an A or a B match.
- R9: In the output modes `pin_out` is the flip-flop for polarity 0 and its complement for polarity 1. In every other mode `pin_out` is low.
- R10: Codes 1000–1111 select PWM at 16, 15, 14, 13, 12, 11, 9 and 7 bits. Time base bits at or above the resolution are ignored, as are the same bits of A and B. A matches set the flip-flop and B matches clear it. The flag pulses on B matches.
- R11: In PWM, writes to A and B go to shadow registers. The active values, shown on `reg_a`/`reg_b`, are loaded from the shadows at the clock edge where the masked time base is zero, and that edge's compare already uses the new values. A == B gives a constant inactive level.
- R12: `flag_out` is high for exactly the one cycle after the clock edge at which its event occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 A, 2 B |
| wr_data | input | TB_W | Write data |
| tbase | input | TB_W | Shared free-running time base |
| pin_in | input | 1 | Asynchronous input pin |
| pin_out | output | 1 | Output pin |
| flag_out | output | 1 | One-cycle event flag |
| reg_a | output | TB_W | Active value of register A |
| reg_b | output | TB_W | Active value of register B |

## Verification
The bench builds the block with a 16-bit time base and a two-stage synchronizer, which are the default parameters. With these defaults, every one of the eight PWM resolutions can be selected. The bench runs whole periods at 14, 13, 12, 11, 9 and 7 bits, with random upper time base bits, to show the masking. It runs partial periods at 16 and 15 bits. Running whole periods exposes wrap-time shadow loads, mid-period writes, a zero duty cycle and a compare value of zero. The two-stage setting makes the capture-latency check land on a fixed cycle.

// File: rtl/dccr_pkg.sv
package dccr_pkg;

    localparam int unsigned MODE_W = 4;

    // Function class decoded from the mode field
    typedef enum logic [2:0] {
        FN_OFF,
        FN_PWIDTH,
        FN_PERIOD,
        FN_CAPT,
        FN_OCB,
        FN_OCAB,
        FN_PWM
    } fn_e;

    // Control register: polarity above mode
    typedef struct packed {
        logic              pol;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    // Edge events after synchronization
    typedef struct packed {
        logic sel;
        logic opp;
    } edge_t;

    // Compare results
    typedef struct packed {
        logic a_hit;
        logic b_hit;
        logic wrap;
    } hit_t;

    function automatic fn_e decode_fn(input logic [MODE_W-1:0] m);
        fn_e f;
        if (m[3]) begin
            f = FN_PWM;
        end else begin
            case (m[2:0])
                3'd1:    f = FN_PWIDTH;
                3'd2:    f = FN_PERIOD;
                3'd3:    f = FN_CAPT;
                3'd4:    f = FN_OCB;
                3'd5:    f = FN_OCAB;
                default: f = FN_OFF;
            endcase
        end
        return f;
    endfunction

    // Number of top time base bits ignored per PWM resolution select
    function automatic int unsigned pwm_drop(input logic [2:0] s);
        int unsigned d;
        case (s)
            3'd6:    d = 7;
            3'd7:    d = 9;
            default: d = int'(s);
        endcase
        return d;
    endfunction

    function automatic logic fn_is_output(input fn_e f);
        return (f == FN_OCB) || (f == FN_OCAB) || (f == FN_PWM);
    endfunction

endpackage

// File: rtl/dccr_edge_sync.sv
module dccr_edge_sync
    import dccr_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_in,
    input  logic  pol,
    output edge_t edges
);

    localparam int unsigned LEN = STAGES + 1;

    logic [LEN-1:0] chain;
    logic           level;
    logic           prev;
    logic           rise;
    logic           fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[LEN-2:0], pin_in};
        end
    end

    assign level = chain[STAGES-1];
    assign prev  = chain[STAGES];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;

    always_comb begin
        edges.sel = pol ? fall : rise;
        edges.opp = pol ? rise : fall;
    end

    generate
        if (STAGES == 2) begin : g_lat_chk
            // R4
            sync_rise_lat_chk: assert property (@(posedge clk) disable iff (rst)
                rise |-> $past(pin_in, 2));
            // R4
            sync_fall_lat_chk: assert property (@(posedge clk) disable iff (rst)
                fall |-> !$past(pin_in, 2));
        end
    endgenerate

endmodule

// File: rtl/dccr_regpair.sv
module dccr_regpair
    import dccr_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  fn_e          fn,
    input  logic [2:0]   res_sel,
    input  edge_t        edges,
    input  logic [W-1:0] tbase,
    input  logic         wr_a,
    input  logic         wr_b,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] act_a,
    output logic [W-1:0] act_b,
    output hit_t         hits
);

    logic [W-1:0] shd_a;
    logic [W-1:0] shd_b;
    logic [W-1:0] mask;
    logic [W-1:0] tb_m;
    logic [W-1:0] cmp_a;
    logic [W-1:0] cmp_b;
    logic         pwm;
    logic         outm;

    assign pwm  = (fn == FN_PWM);
    assign outm = fn_is_output(fn);

    always_comb begin
        if (pwm) begin
            mask = {W{1'b1}} >> pwm_drop(res_sel);
        end else begin
            mask = {W{1'b1}};
        end
    end

    assign tb_m = tbase & mask;

    always_comb begin
        hits.wrap  = pwm && (tb_m == '0);
        cmp_a      = hits.wrap ? shd_a : act_a;
        cmp_b      = hits.wrap ? shd_b : act_b;
        hits.a_hit = outm && ((cmp_a & mask) == tb_m);
        hits.b_hit = outm && ((cmp_b & mask) == tb_m);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_a <= '0;
            act_b <= '0;
            shd_a <= '0;
            shd_b <= '0;
        end else begin
            if (wr_a) begin
                shd_a <= wr_data;
                if (!pwm) act_a <= wr_data;
            end
            if (wr_b) begin
                shd_b <= wr_data;
                if (!pwm) act_b <= wr_data;
            end
            if (hits.wrap) begin
                act_a <= shd_a;
                act_b <= shd_b;
            end
            case (fn)
                FN_PWIDTH: begin
                    if (edges.sel) act_a <= tbase;
                    if (edges.opp) act_b <= tbase;
                end
                FN_PERIOD: begin
                    if (edges.sel) begin
                        act_b <= act_a;
                        act_a <= tbase;
                    end
                end
                FN_CAPT: begin
                    if (edges.sel) act_a <= tbase;
                end
                default: ;
            endcase
        end
    end

    // R11
    pwm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pwm && !hits.wrap) |=> ($stable(act_a) && $stable(act_b)));

    // R5
    capt_load_chk: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_CAPT && edges.sel) |=> (act_a == $past(tbase)));

    // R7
    period_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_PERIOD && edges.sel) |=> (act_b == $past(act_a)));

endmodule

// File: rtl/dccr_pin_drive.sv
module dccr_pin_drive
    import dccr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fn_e   fn,
    input  logic  pol,
    input  edge_t edges,
    input  hit_t  hits,
    output logic  pin_out,
    output logic  flag_out
);

    logic ff;
    logic evt;
    logic outm;

    assign outm = fn_is_output(fn);

    always_comb begin
        case (fn)
            FN_PWIDTH:     evt = edges.opp;
            FN_PERIOD:     evt = edges.sel;
            FN_CAPT:       evt = edges.sel;
            FN_OCB:        evt = hits.b_hit;
            FN_PWM:        evt = hits.b_hit;
            FN_OCAB:       evt = hits.a_hit | hits.b_hit;
            default:       evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ff       <= 1'b0;
            flag_out <= 1'b0;
        end else begin
            flag_out <= evt;
            if (!outm) begin
                ff <= 1'b0;
            end else if (hits.b_hit) begin
                ff <= 1'b0;
            end else if (hits.a_hit) begin
                ff <= 1'b1;
            end
        end
    end

    assign pin_out = outm & (ff ^ pol);

    // R8
    b_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (outm && hits.b_hit) |=> !ff);

    // R8
    a_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (outm && hits.a_hit && !hits.b_hit) |=> ff);

    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (fn == FN_OFF) |=> !flag_out);

endmodule

// File: rtl/dual_ccr_timer.sv
module dual_ccr_timer
    import dccr_pkg::*;
#(
    parameter int unsigned TB_W        = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [TB_W-1:0] wr_data,
    input  logic [TB_W-1:0] tbase,
    input  logic            pin_in,
    output logic            pin_out,
    output logic            flag_out,
    output logic [TB_W-1:0] reg_a,
    output logic [TB_W-1:0] reg_b
);

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    ctrl_t ctrl;
    fn_e   fn;
    edge_t edges;
    hit_t  hits;
    logic  wr_ctrl;
    logic  wr_a;
    logic  wr_b;

    assign wr_ctrl = wr_en && (wr_sel == 2'd0);
    assign wr_a    = wr_en && (wr_sel == 2'd1);
    assign wr_b    = wr_en && (wr_sel == 2'd2);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    assign fn = decode_fn(ctrl.mode);

    dccr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .pol    (ctrl.pol),
        .edges  (edges)
    );

    dccr_regpair #(.W(TB_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .fn      (fn),
        .res_sel (ctrl.mode[2:0]),
        .edges   (edges),
        .tbase   (tbase),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .wr_data (wr_data),
        .act_a   (reg_a),
        .act_b   (reg_b),
        .hits    (hits)
    );

    dccr_pin_drive u_drive (
        .clk      (clk),
        .rst      (rst),
        .fn       (fn),
        .pol      (ctrl.pol),
        .edges    (edges),
        .hits     (hits),
        .pin_out  (pin_out),
        .flag_out (flag_out)
    );

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl));

endmodule

// File: tb/dual_ccr_timer_tb.sv
`timescale 1ns/1ps
module dual_ccr_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic [15:0] tbase;
    logic        pin_in;
    logic        pin_out;
    logic        flag_out;
    logic [15:0] reg_a;
    logic [15:0] reg_b;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dual_ccr_timer #(.TB_W(16), .SYNC_STAGES(2)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .tbase    (tbase),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .flag_out (flag_out),
        .reg_a    (reg_a),
        .reg_b    (reg_b)
    );

    function automatic int res_bits(input int sel);
        case (sel)
            0: return 16;
            1: return 15;
            2: return 14;
            3: return 13;
            4: return 12;
            5: return 11;
            6: return 9;
            default: return 7;
        endcase
    endfunction

    function automatic logic [15:0] mask_of(input int sel);
        logic [31:0] m;
        m = (32'h1 << res_bits(sel)) - 32'h1;
        return m[15:0];
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        wr_en   = 1'b1;
        wr_sel  = s;
        wr_data = d;
        step(1);
        wr_en   = 1'b0;
    endtask

    task automatic pwm_run(input int sel, input bit pol,
                           input logic [15:0] a, input logic [15:0] b,
                           input int ncyc, input int chg_at,
                           input logic [15:0] na, input logic [15:0] nb);
        logic [15:0] msk;
        logic [15:0] sa, sb, ma, mb, m;
        bit          ff, ha, hb;
        msk = mask_of(sel);
        tbase = 16'h0;
        wr(2'd0, 16'h0);
        wr(2'd1, a);
        wr(2'd2, b);
        wr(2'd0, {11'd0, pol, 1'b1, 3'(sel)});
        sa = a; sb = b; ma = a; mb = b; ff = 1'b0; m = 16'h0;
        for (int i = 0; i < ncyc; i++) begin
            tbase = (16'($urandom) & ~msk) | m;
            if (i == chg_at) begin
                wr_en = 1'b1; wr_sel = 2'd1; wr_data = na;
            end else if (i == chg_at + 1) begin
                wr_en = 1'b1; wr_sel = 2'd2; wr_data = nb;
            end
            if (m == 16'h0) begin
                ma = sa;
                mb = sb;
            end
            hb = ((mb & msk) == m);
            ha = ((ma & msk) == m);
            if (hb) ff = 1'b0;
            else if (ha) ff = 1'b1;
            if (i == chg_at) sa = na;
            if (i == chg_at + 1) sb = nb;
            step(1);
            wr_en = 1'b0;
            chk("R10 pwm pin level", {31'd0, pin_out}, {31'd0, ff ^ pol});
            chk("R10 pwm B flag", {31'd0, flag_out}, {31'd0, hb});
            chk("R11 active A", {16'd0, reg_a}, {16'd0, ma});
            chk("R11 active B", {16'd0, reg_b}, {16'd0, mb});
            m = (m + 16'h1) & msk;
        end
        tbase = 16'h0;
        wr(2'd0, 16'h0);
    endtask

    initial begin
        logic [15:0] v, old_a, old_b, prev_a;
        void'($urandom(32'h00C0FFEE));
        rst = 1'b1; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 16'h0;
        tbase = 16'h0; pin_in = 1'b0;
        step(4);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk("R1 pin_out", {31'd0, pin_out}, 32'd0);
        chk("R1 flag", {31'd0, flag_out}, 32'd0);
        chk("R1 reg_a", {16'd0, reg_a}, 32'd0);
        chk("R1 reg_b", {16'd0, reg_b}, 32'd0);

        // R2 direct writes outside PWM
        wr(2'd1, 16'h1234);
        chk("R2 write A", {16'd0, reg_a}, 32'h1234);
        wr(2'd2, 16'h5678);
        chk("R2 write B", {16'd0, reg_b}, 32'h5678);

        // R3 disabled and reserved codes
        for (int mi = 0; mi < 3; mi++) begin
            logic [3:0] code;
            code = (mi == 0) ? 4'b0000 : ((mi == 1) ? 4'b0110 : 4'b0111);
            wr(2'd0, {11'd0, 1'(mi != 0), code});
            for (int k = 0; k < 8; k++) begin
                tbase  = (k % 2 == 0) ? 16'h1234 : 16'h5678;
                pin_in = ~pin_in;
                step(1);
                chk("R3 flag low", {31'd0, flag_out}, 32'd0);
                chk("R3 pin low", {31'd0, pin_out}, 32'd0);
                chk("R3 A kept", {16'd0, reg_a}, 32'h1234);
                chk("R3 B kept", {16'd0, reg_b}, 32'h5678);
            end
            pin_in = 1'b0;
            step(4);
        end

        // R4 R5 input capture, both polarities
        for (int p = 0; p < 2; p++) begin
            tbase = 16'h0;
            wr(2'd0, {11'd0, 1'(p), 4'b0011});
            pin_in = 1'(p);
            step(4);
            chk("R9 pin low in input mode", {31'd0, pin_out}, 32'd0);
            old_a = reg_a;
            old_b = reg_b;
            for (int k = 0; k < 6; k++) begin
                v = 16'($urandom);
                tbase  = v;
                pin_in = ~1'(p);
                step(2);
                chk("R4 no early capture", {16'd0, reg_a}, {16'd0, old_a});
                step(1);
                chk("R5 capture on active edge", {16'd0, reg_a}, {16'd0, v});
                chk("R5 capture flag", {31'd0, flag_out}, 32'd1);
                step(1);
                chk("R12 flag one cycle", {31'd0, flag_out}, 32'd0);
                tbase  = 16'($urandom);
                pin_in = 1'(p);
                step(3);
                chk("R5 other edge ignored", {16'd0, reg_a}, {16'd0, v});
                chk("R5 other edge no flag", {31'd0, flag_out}, 32'd0);
                chk("R5 B untouched", {16'd0, reg_b}, {16'd0, old_b});
                old_a = v;
            end
        end

        // R6 pulse width
        for (int p = 0; p < 2; p++) begin
            wr(2'd0, {11'd0, 1'(p), 4'b0001});
            pin_in = 1'(p);
            step(4);
            for (int k = 0; k < 3; k++) begin
                v = 16'($urandom);
                tbase = v; pin_in = ~1'(p);
                step(3);
                chk("R6 lead edge to A", {16'd0, reg_a}, {16'd0, v});
                chk("R6 lead edge no flag", {31'd0, flag_out}, 32'd0);
                v = 16'($urandom);
                tbase = v; pin_in = 1'(p);
                step(3);
                chk("R6 trail edge to B", {16'd0, reg_b}, {16'd0, v});
                chk("R6 trail edge flag", {31'd0, flag_out}, 32'd1);
            end
        end

        // R7 period
        wr(2'd0, 16'h0002);
        pin_in = 1'b0;
        step(4);
        for (int k = 0; k < 4; k++) begin
            prev_a = reg_a;
            v = 16'($urandom);
            tbase = v; pin_in = 1'b1;
            step(3);
            chk("R7 new A", {16'd0, reg_a}, {16'd0, v});
            chk("R7 old A into B", {16'd0, reg_b}, {16'd0, prev_a});
            chk("R7 flag", {31'd0, flag_out}, 32'd1);
            tbase = 16'($urandom); pin_in = 1'b0;
            step(3);
            chk("R7 opposite edge ignored", {16'd0, reg_a}, {16'd0, v});
            chk("R7 opposite no flag", {31'd0, flag_out}, 32'd0);
        end

        // R8 R9 output compare
        tbase = 16'h0;
        wr(2'd0, 16'h0);
        wr(2'd1, 16'd100);
        wr(2'd2, 16'd200);
        wr(2'd0, 16'h0004);
        chk("R9 pol0 idle low", {31'd0, pin_out}, 32'd0);
        tbase = 16'd100; step(1);
        chk("R8 A match sets", {31'd0, pin_out}, 32'd1);
        chk("R8 OCB no flag on A", {31'd0, flag_out}, 32'd0);
        tbase = 16'd150; step(1);
        chk("R8 holds between", {31'd0, pin_out}, 32'd1);
        tbase = 16'd200; step(1);
        chk("R8 B match clears", {31'd0, pin_out}, 32'd0);
        chk("R8 OCB flag on B", {31'd0, flag_out}, 32'd1);
        tbase = 16'd150; step(1);
        chk("R12 flag drops", {31'd0, flag_out}, 32'd0);
        tbase = 16'h0;
        wr(2'd0, 16'h0);
        wr(2'd0, 16'h0015);
        chk("R9 pol1 idle high", {31'd0, pin_out}, 32'd1);
        tbase = 16'd100; step(1);
        chk("R9 pol1 A match low", {31'd0, pin_out}, 32'd0);
        chk("R8 OCAB flag on A", {31'd0, flag_out}, 32'd1);
        tbase = 16'd0; step(1);
        chk("R8 OCAB quiet", {31'd0, flag_out}, 32'd0);
        tbase = 16'd200; step(1);
        chk("R9 pol1 B match high", {31'd0, pin_out}, 32'd1);
        chk("R8 OCAB flag on B", {31'd0, flag_out}, 32'd1);
        tbase = 16'h0;
        wr(2'd0, 16'h0);
        wr(2'd2, 16'd100);
        wr(2'd0, 16'h0004);
        tbase = 16'd100; step(1);
        chk("R8 equal match clear wins", {31'd0, pin_out}, 32'd0);
        chk("R8 equal match flag", {31'd0, flag_out}, 32'd1);
        tbase = 16'h0;
        wr(2'd0, 16'h0);

        // R10 R11 PWM
        pwm_run(7, 1'b0, 16'($urandom), 16'($urandom), 400, 200, 16'($urandom), 16'($urandom));
        pwm_run(7, 1'b1, 16'hAB20, 16'h1260, 300, 150, 16'h0000, 16'h7F50);
        pwm_run(7, 1'b0, 16'h0030, 16'hF030, 300, -5, 16'h0, 16'h0);
        pwm_run(7, 1'b0, 16'h0000, 16'h0040, 300, -5, 16'h0, 16'h0);
        pwm_run(6, 1'b1, 16'($urandom), 16'($urandom), 1100, 600, 16'($urandom), 16'($urandom));
        for (int s = 2; s < 6; s++) begin
            int per;
            per = 1 << res_bits(s);
            pwm_run(s, 1'(s % 2), 16'($urandom), 16'($urandom), per + 200, per / 2 + 3,
                    16'($urandom), 16'($urandom));
        end
        pwm_run(0, 1'b0, 16'($urandom % 400), 16'($urandom % 400), 600, -5, 16'h0, 16'h0);
        pwm_run(1, 1'b1, 16'($urandom % 400) | 16'h8000, 16'($urandom % 400), 600, -5, 16'h0, 16'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule